// File: doc/BRIEF.md
# Reduce Packet Chunker

The block splits one reduce transfer into a run of packet-sized pieces. A request supplies an element count, a datatype code, a priority class and an architecture identifier. The block works out how many bytes the whole transfer holds. It then derives a packet size from that total, the byte cap programmed for the request's priority class and the element limit of the architecture. Finally it hands out chunk descriptors, each an offset and a length, through a valid/ready port until the whole transfer is covered.

The request fields are captured when `start` is taken, so they may change freely afterwards. The per-class caps are read once, in the evaluation cycle, and the packet size derived from them is held for the rest of the run. A bad request ends with a one-cycle `error` pulse and no chunks. A good request ends with a one-cycle `done` pulse.

The controller has five states. In IDLE a `start` pulse captures the request and the machine moves to CHECK. In CHECK the packet size is evaluated and registered. CHECK then goes to FAULT when the configuration is bad or when the packet size rounds to zero while bytes remain. It goes to FINISH when the transfer is empty, and to EMIT otherwise. EMIT presents one chunk per handshake and moves to FINISH once the chunk carrying the last bytes is accepted. FINISH raises `done` and FAULT raises `error`, each for one cycle, and both then return to IDLE.

Top module: `reduce_chunker`

## Requirements
- R1: Element byte size by datatype code: 2, 3, 13, 14 and 15 are 1 byte; 4, 5, 6 and 7 are 2 bytes; 8, 9 and 10 are 4 bytes; 1 and 12 are 8 bytes. The transfer size in bytes is the element byte size times the element count.
- R2: A priority class above 4 ends the request with an `error` pulse two cycles after `start` is taken, and no chunk is offered.
- R3: A datatype code whose byte size is zero (codes 0 and 11) ends the request with an `error` pulse and no chunks.
- R4: Architecture identifier 2 gives a limit of 1024 elements per packet, and identifiers 3 and 4 give 2048. Any other identifier ends the request with an `error` pulse and no chunks.
- R5: When the cap of the request's class is nonzero and smaller than the transfer size, the packet size becomes that cap. A cap of zero means the class has no cap.
- R6: The packet size never exceeds the element limit times the element byte size.
- R7: After the cap and the limit are applied, the packet size is rounded down to a multiple of 32 bytes.
- R8: Chunks start at offset 0 and are contiguous. Every chunk except the last has the packet size. The last chunk carries the remaining bytes, which need not be a multiple of 32. The chunk lengths add up to the transfer size.
- R9: `done` is high for exactly one cycle, the cycle right after the final chunk is accepted.
- R10: An element count of zero gives a `done` pulse two cycles after `start` is taken, with no chunks.
- R11: When the rounded packet size is zero while the transfer size is nonzero, the request ends with an `error` pulse instead of chunks.
- R12: While `chunk_valid` is high and `chunk_ready` is low, `chunk_valid`, `chunk_off` and `chunk_len` hold their values.
- R13: A `start` pulse that arrives while a request is in progress has no effect. Changes to the request inputs during a run also have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, taken in IDLE |
| elem_count | input | CNT_W | Number of elements in the transfer |
| dtype_code | input | 4 | Datatype code |
| prio_class | input | PRIO_W | Priority class |
| arch_id | input | ARCH_W | Architecture identifier |
| class_caps | input | NUM_CLASS*BYTE_W | Byte cap per class, class k in bits [k*BYTE_W +: BYTE_W], zero means no cap |
| chunk_ready | input | 1 | Consumer accepts the current chunk |
| chunk_valid | output | 1 | A chunk descriptor is on offer |
| chunk_off | output | BYTE_W | Byte offset of the chunk |
| chunk_len | output | BYTE_W | Byte length of the chunk |
| done | output | 1 | One-cycle pulse after the final chunk, or for an empty transfer |
| error | output | 1 | One-cycle pulse for a rejected request |

## Verification
The assertions assume that reset is applied before the first request. They also assume that `class_caps` is stable in the cycle after `start` is taken, because that is the only cycle in which the caps are read. The stimulus changes the caps only between runs, while the block is idle. It deliberately does change the request fields, and pulses `start` again, in the middle of a run, to show that neither has any effect. The consumer follows two patterns: `chunk_ready` held high, and `chunk_ready` low on every third cycle. The second pattern exercises the hold behaviour while stalled.

// File: rtl/reduce_chunker_pkg.sv
package reduce_chunker_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_EMIT,
        ST_FINISH,
        ST_FAULT
    } chunk_state_e;

    localparam int DTYPE_W = 4;
    localparam int SIZE_W  = 4;
endpackage

// File: rtl/rc_dtype_size.sv
module rc_dtype_size
    import reduce_chunker_pkg::*;
(
    input  logic [DTYPE_W-1:0] code,
    output logic [SIZE_W-1:0]  nbytes
);
    always_comb begin
        unique case (code)
            4'd2, 4'd3, 4'd13, 4'd14, 4'd15: nbytes = 4'd1;
            4'd4, 4'd5, 4'd6, 4'd7:          nbytes = 4'd2;
            4'd8, 4'd9, 4'd10:               nbytes = 4'd4;
            4'd1, 4'd12:                     nbytes = 4'd8;
            default:                         nbytes = 4'd0;
        endcase
    end
endmodule

// File: rtl/rc_pkt_size.sv
module rc_pkt_size
    import reduce_chunker_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int BYTE_W      = CNT_W + 4,
    parameter int NUM_CLASS   = 5,
    parameter int PRIO_W      = 3,
    parameter int ARCH_W      = 3,
    parameter int ARCH_SMALL  = 2,
    parameter int ARCH_LG_LO  = 3,
    parameter int ARCH_LG_HI  = 4,
    parameter int LIMIT_SMALL = 1024,
    parameter int LIMIT_LARGE = 2048,
    parameter int GRAIN       = 32
) (
    input  logic [CNT_W-1:0]            count,
    input  logic [SIZE_W-1:0]           nbytes,
    input  logic [PRIO_W-1:0]           prio,
    input  logic [ARCH_W-1:0]           arch,
    input  logic [NUM_CLASS*BYTE_W-1:0] caps,
    output logic [BYTE_W-1:0]           total_bytes,
    output logic [BYTE_W-1:0]           pkt_bytes,
    output logic                        cfg_bad
);
    localparam logic [BYTE_W-1:0] GRAIN_MASK = ~BYTE_W'(GRAIN - 1);
    localparam logic [BYTE_W-1:0] LIM_S      = BYTE_W'(LIMIT_SMALL);
    localparam logic [BYTE_W-1:0] LIM_L      = BYTE_W'(LIMIT_LARGE);

    logic [BYTE_W-1:0] cap_arr [NUM_CLASS];
    logic [BYTE_W-1:0] cap_sel;
    logic [BYTE_W-1:0] lim_elems;
    logic [BYTE_W-1:0] lim_bytes;
    logic [BYTE_W-1:0] after_cap;
    logic [BYTE_W-1:0] after_lim;
    logic              prio_bad;
    logic              arch_bad;

    genvar g;
    generate
        for (g = 0; g < NUM_CLASS; g++) begin : g_cap
            assign cap_arr[g] = caps[g*BYTE_W +: BYTE_W];
        end
    endgenerate

    always_comb begin
        cap_sel  = '0;
        prio_bad = 1'b1;
        for (int i = 0; i < NUM_CLASS; i++) begin
            if (prio == PRIO_W'(i)) begin
                cap_sel  = cap_arr[i];
                prio_bad = 1'b0;
            end
        end
    end

    always_comb begin
        arch_bad  = 1'b0;
        lim_elems = '0;
        if (arch == ARCH_W'(ARCH_SMALL)) begin
            lim_elems = LIM_S;
        end else if (arch >= ARCH_W'(ARCH_LG_LO) && arch <= ARCH_W'(ARCH_LG_HI)) begin
            lim_elems = LIM_L;
        end else begin
            arch_bad = 1'b1;
        end
    end

    assign total_bytes = BYTE_W'(count) * BYTE_W'(nbytes);
    assign lim_bytes   = lim_elems * BYTE_W'(nbytes);
    assign after_cap   = (cap_sel != '0 && total_bytes > cap_sel) ? cap_sel : total_bytes;
    assign after_lim   = (after_cap > lim_bytes) ? lim_bytes : after_cap;
    assign pkt_bytes   = after_lim & GRAIN_MASK;
    assign cfg_bad     = prio_bad | arch_bad | (nbytes == '0);
endmodule

// File: rtl/rc_chunk_seq.sv
module rc_chunk_seq
    import reduce_chunker_pkg::*;
#(
    parameter int BYTE_W = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] total_bytes,
    input  logic [BYTE_W-1:0] pkt_bytes,
    input  logic              cfg_bad,
    input  logic              chunk_ready,
    output logic              take_req,
    output logic              chunk_valid,
    output logic [BYTE_W-1:0] chunk_off,
    output logic [BYTE_W-1:0] chunk_len,
    output logic              done,
    output logic              error
);
    chunk_state_e state_q, state_d;
    logic [BYTE_W-1:0] off_q, rem_q, pkt_q;
    logic              handshake;
    logic              final_piece;

    assign handshake   = chunk_valid && chunk_ready;
    assign final_piece = rem_q <= pkt_q;
    assign chunk_off   = off_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_CHECK;
            ST_CHECK: begin
                if (cfg_bad)                 state_d = ST_FAULT;
                else if (total_bytes == '0)  state_d = ST_FINISH;
                else if (pkt_bytes == '0)    state_d = ST_FAULT;
                else                         state_d = ST_EMIT;
            end
            ST_EMIT:   if (handshake && final_piece) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        take_req    = 1'b0;
        chunk_valid = 1'b0;
        done        = 1'b0;
        error       = 1'b0;
        chunk_len   = final_piece ? rem_q : pkt_q;
        unique case (state_q)
            ST_IDLE:   take_req    = start;
            ST_CHECK:  ;
            ST_EMIT:   chunk_valid = 1'b1;
            ST_FINISH: done        = 1'b1;
            ST_FAULT:  error       = 1'b1;
            default:   ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q <= '0;
            rem_q <= '0;
            pkt_q <= '0;
        end else if (state_q == ST_CHECK) begin
            off_q <= '0;
            rem_q <= total_bytes;
            pkt_q <= pkt_bytes;
        end else if (handshake) begin
            off_q <= off_q + chunk_len;
            rem_q <= rem_q - chunk_len;
        end
    end
endmodule

// File: rtl/reduce_chunker.sv
module reduce_chunker
    import reduce_chunker_pkg::*;
#(
    parameter int CNT_W     = 24,
    parameter int BYTE_W    = CNT_W + 4,
    parameter int NUM_CLASS = 5,
    parameter int PRIO_W    = 3,
    parameter int ARCH_W    = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [CNT_W-1:0]            elem_count,
    input  logic [DTYPE_W-1:0]          dtype_code,
    input  logic [PRIO_W-1:0]           prio_class,
    input  logic [ARCH_W-1:0]           arch_id,
    input  logic [NUM_CLASS*BYTE_W-1:0] class_caps,
    input  logic                        chunk_ready,
    output logic                        chunk_valid,
    output logic [BYTE_W-1:0]           chunk_off,
    output logic [BYTE_W-1:0]           chunk_len,
    output logic                        done,
    output logic                        error
);
    logic [CNT_W-1:0]   cnt_q;
    logic [DTYPE_W-1:0] dt_q;
    logic [PRIO_W-1:0]  prio_q;
    logic [ARCH_W-1:0]  arch_q;
    logic               take_req;
    logic [SIZE_W-1:0]  nbytes;
    logic [BYTE_W-1:0]  total_bytes;
    logic [BYTE_W-1:0]  pkt_bytes;
    logic               cfg_bad;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            dt_q   <= '0;
            prio_q <= '0;
            arch_q <= '0;
        end else if (take_req) begin
            cnt_q  <= elem_count;
            dt_q   <= dtype_code;
            prio_q <= prio_class;
            arch_q <= arch_id;
        end
    end

    rc_dtype_size u_size (
        .code   (dt_q),
        .nbytes (nbytes)
    );

    rc_pkt_size #(
        .CNT_W     (CNT_W),
        .BYTE_W    (BYTE_W),
        .NUM_CLASS (NUM_CLASS),
        .PRIO_W    (PRIO_W),
        .ARCH_W    (ARCH_W)
    ) u_pkt (
        .count       (cnt_q),
        .nbytes      (nbytes),
        .prio        (prio_q),
        .arch        (arch_q),
        .caps        (class_caps),
        .total_bytes (total_bytes),
        .pkt_bytes   (pkt_bytes),
        .cfg_bad     (cfg_bad)
    );

    rc_chunk_seq #(
        .BYTE_W (BYTE_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .total_bytes (total_bytes),
        .pkt_bytes   (pkt_bytes),
        .cfg_bad     (cfg_bad),
        .chunk_ready (chunk_ready),
        .take_req    (take_req),
        .chunk_valid (chunk_valid),
        .chunk_off   (chunk_off),
        .chunk_len   (chunk_len),
        .done        (done),
        .error       (error)
    );
endmodule

// File: rtl/reduce_chunker_checker.sv
module reduce_chunker_checker #(
    parameter int BYTE_W    = 28,
    parameter int GRAIN     = 32,
    parameter int MAX_BYTES = 2048 * 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chunk_ready,
    input logic              chunk_valid,
    input logic [BYTE_W-1:0] chunk_off,
    input logic [BYTE_W-1:0] chunk_len,
    input logic              done,
    input logic              error
);
    a_r12_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_valid && !chunk_ready |=> chunk_valid && $stable(chunk_off) && $stable(chunk_len));

    a_r8_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_valid && chunk_ready |=>
            done || (chunk_valid && chunk_off == $past(chunk_off) + $past(chunk_len)));

    a_r8_remainder_last: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_valid && chunk_ready && (chunk_len & BYTE_W'(GRAIN - 1)) != '0 |=> done);

    a_r8_nonzero_len: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_valid |-> chunk_len != '0);

    a_r6_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_valid |-> chunk_len <= BYTE_W'(MAX_BYTES));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_error_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> !error);

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error) && !(chunk_valid && (done || error)));
endmodule

bind reduce_chunker reduce_chunker_checker #(.BYTE_W(BYTE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .chunk_ready (chunk_ready),
    .chunk_valid (chunk_valid),
    .chunk_off   (chunk_off),
    .chunk_len   (chunk_len),
    .done        (done),
    .error       (error)
);

// File: tb/reduce_chunker_test.sv
module reduce_chunker_test;
    localparam int CNT_W  = 24;
    localparam int BYTE_W = CNT_W + 4;
    localparam int NC     = 5;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic [CNT_W-1:0]     elem_count = '0;
    logic [3:0]           dtype_code = '0;
    logic [2:0]           prio_class = '0;
    logic [2:0]           arch_id = '0;
    logic [NC*BYTE_W-1:0] class_caps = '0;
    logic                 chunk_ready = 1'b1;
    logic                 chunk_valid;
    logic [BYTE_W-1:0]    chunk_off;
    logic [BYTE_W-1:0]    chunk_len;
    logic                 done;
    logic                 error;

    reduce_chunker uut (
        .clk(clk), .rst_n(rst_n), .start(start), .elem_count(elem_count),
        .dtype_code(dtype_code), .prio_class(prio_class), .arch_id(arch_id),
        .class_caps(class_caps), .chunk_ready(chunk_ready), .chunk_valid(chunk_valid),
        .chunk_off(chunk_off), .chunk_len(chunk_len), .done(done), .error(error)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int rdy_mode = 0;
    int cyc = 0;

    // reference model
    int mph = 0;          // 0 idle, 1 evaluating, 2 streaming, 3 finished, 4 rejected
    int q[$];
    int m_off = 0;
    bit m_bad = 0;

    // per-run observations
    int hs_n = 0;
    int hs_sum = 0;
    int first_len = 0;
    bit saw_done = 0;
    bit saw_err = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int dsize(input int c);
        case (c)
            2, 3, 13, 14, 15: return 1;
            4, 5, 6, 7:       return 2;
            8, 9, 10:         return 4;
            1, 12:            return 8;
            default:          return 0;
        endcase
    endfunction

    task automatic plan_request();
        int sz, want, pkt, cap, lim, rem;
        q.delete();
        sz = dsize(int'(dtype_code));
        m_bad = (prio_class > 3'd4) || (sz == 0) || !(arch_id >= 3'd2 && arch_id <= 3'd4);
        if (m_bad) return;
        want = sz * int'(elem_count);
        cap  = int'(class_caps[int'(prio_class)*BYTE_W +: BYTE_W]);
        pkt  = want;
        if (cap != 0 && want > cap) pkt = cap;
        lim  = ((arch_id == 3'd2) ? 1024 : 2048) * sz;
        if (pkt > lim) pkt = lim;
        pkt = (pkt / 32) * 32;
        if (want > 0 && pkt == 0) begin
            m_bad = 1;
            return;
        end
        rem = want;
        while (rem > 0) begin
            q.push_back((rem > pkt) ? pkt : rem);
            rem -= (rem > pkt) ? pkt : rem;
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk(chunk_valid == (mph == 2), "R8", "chunk_valid", chunk_valid, mph == 2);
            if (mph == 2 && chunk_valid) begin
                chk(chunk_off == BYTE_W'(m_off), "R8", "chunk_off", chunk_off, m_off);
                chk(chunk_len == BYTE_W'(q[0]), "R8", "chunk_len", chunk_len, q[0]);
            end
            chk(done == (mph == 3), "R9", "done", done, mph == 3);
            chk(error == (mph == 4), "R2", "error", error, mph == 4);
            if (chunk_valid && chunk_ready) begin
                hs_n++;
                hs_sum += int'(chunk_len);
                if (hs_n == 1) first_len = int'(chunk_len);
            end
            if (done) saw_done = 1;
            if (error) saw_err = 1;
            case (mph)
                0: if (start) begin plan_request(); mph = 1; end
                1: begin
                    m_off = 0;
                    mph = m_bad ? 4 : ((q.size() == 0) ? 3 : 2);
                end
                2: if (chunk_ready) begin
                    m_off += q.pop_front();
                    if (q.size() == 0) mph = 3;
                end
                default: mph = 0;
            endcase
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            #2;
            cyc++;
            chunk_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
        end
    end

    task automatic set_cap(input int idx, input int val);
        class_caps[idx*BYTE_W +: BYTE_W] = BYTE_W'(val);
    endtask

    task automatic wait_end();
        while (!(saw_done || saw_err)) @(negedge clk);
        repeat (2) @(posedge clk);
    endtask

    task automatic launch(input int dt, input int cnt, input int pr, input int ar, input int rm);
        @(posedge clk);
        #2;
        dtype_code = 4'(dt);
        elem_count = CNT_W'(cnt);
        prio_class = 3'(pr);
        arch_id    = 3'(ar);
        rdy_mode   = rm;
        hs_n = 0; hs_sum = 0; first_len = 0; saw_done = 0; saw_err = 0;
        start = 1'b1;
        @(posedge clk);
        #2;
        start = 1'b0;
    endtask

    task automatic run(input int dt, input int cnt, input int pr, input int ar, input int rm);
        launch(dt, cnt, pr, ar, rm);
        wait_end();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(chunk_valid == 1'b0 && done == 1'b0 && error == 1'b0, "R9", "reset outputs",
            {chunk_valid, done, error}, 0);
        rst_n = 1'b1;

        // R1 R7 R8: 4-byte code, 400 bytes -> 384 then a 16-byte tail
        run(9, 100, 0, 3, 0);
        chk(hs_n == 2, "R8", "chunk count", hs_n, 2);
        chk(first_len == 384, "R7", "packet size", first_len, 384);
        chk(hs_sum == 400, "R1", "total bytes", hs_sum, 400);

        // R1: 8-byte code, 80 bytes
        run(1, 10, 0, 3, 1);
        chk(first_len == 64 && hs_sum == 80, "R1", "8-byte total", hs_sum, 80);

        // R5: class 1 cap 100 -> 96-byte packets with stalls (R12)
        set_cap(1, 100);
        run(2, 1000, 1, 4, 1);
        chk(first_len == 96, "R5", "capped packet", first_len, 96);
        chk(hs_n == 11 && hs_sum == 1000, "R12", "stalled stream chunks", hs_n, 11);

        // R5: cap larger than request has no effect
        set_cap(2, 5000);
        run(4, 300, 2, 3, 0);
        chk(first_len == 576 && hs_n == 2, "R5", "uncapped packet", first_len, 576);

        // R6 R4: element limits per architecture
        run(13, 3000, 0, 2, 0);
        chk(first_len == 1024 && hs_n == 3, "R6", "arch 2 limit", first_len, 1024);
        run(13, 3000, 0, 4, 1);
        chk(first_len == 2048 && hs_n == 2, "R6", "arch 4 limit", first_len, 2048);
        run(5, 3000, 0, 3, 0);
        chk(first_len == 4096, "R4", "arch 3 limit 2-byte", first_len, 4096);

        // R3: zero-size codes
        run(11, 50, 0, 3, 0);
        chk(saw_err && hs_n == 0, "R3", "code 11 rejected", saw_err, 1);
        run(0, 50, 0, 3, 0);
        chk(saw_err && hs_n == 0, "R3", "code 0 rejected", saw_err, 1);

        // R2: class out of range
        run(9, 50, 5, 3, 0);
        chk(saw_err && hs_n == 0, "R2", "class 5 rejected", saw_err, 1);
        run(9, 50, 7, 3, 0);
        chk(saw_err && hs_n == 0, "R2", "class 7 rejected", saw_err, 1);

        // R4: bad architecture
        run(9, 50, 0, 1, 0);
        chk(saw_err && hs_n == 0, "R4", "arch 1 rejected", saw_err, 1);
        run(9, 50, 0, 5, 0);
        chk(saw_err && hs_n == 0, "R4", "arch 5 rejected", saw_err, 1);

        // R11: packet rounds to zero
        run(2, 20, 0, 3, 0);
        chk(saw_err && hs_n == 0, "R11", "sub-grain request", saw_err, 1);
        set_cap(3, 16);
        run(9, 500, 3, 3, 0);
        chk(saw_err && hs_n == 0, "R11", "tiny cap", saw_err, 1);

        // R10: empty transfer
        run(9, 0, 0, 3, 0);
        chk(saw_done && !saw_err && hs_n == 0, "R10", "empty transfer", saw_done, 1);

        // R13: second start and changed inputs during a run are ignored
        launch(2, 1000, 1, 4, 1);
        repeat (3) @(posedge clk);
        #2;
        dtype_code = 4'd11;
        elem_count = CNT_W'(7);
        start = 1'b1;
        @(posedge clk);
        #2;
        start = 1'b0;
        wait_end();
        chk(!saw_err && hs_n == 11 && hs_sum == 1000, "R13", "restart ignored", hs_sum, 1000);

        // R9: done after exact multiple of packet
        set_cap(4, 64);
        run(2, 128, 4, 3, 1);
        chk(saw_done && hs_n == 2 && first_len == 64, "R9", "even split", hs_n, 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule